// File: doc/BRIEF.md
# Address Decode Window Unit

This unit steers each transaction address to a destination by comparing it against five programmable address windows at once. Every window has its own enable, a 4-bit destination code, a base, a size and a remap base, all held in a small register file written and read through a plain word-addressed register port. A window covers a power-of-two region given as a mask in 64 KB units. When an address falls inside an enabled window, the unit reports a hit, returns that window's destination code, and forms a translated address. The upper bits of the translated address come from the remap base and the offset inside the window is carried through unchanged.

Lookups are purely combinational and pass through a valid/ready pair without storage. `res_valid` follows `lk_valid` and `lk_ready` follows `res_ready`, so back-pressure from the consumer reaches the producer in the same cycle. Nothing is held when `res_ready` is low. The producer must keep `lk_addr` stable until the transfer completes, and the result fields have meaning only while `res_valid` is high. When windows overlap, the lowest-numbered window wins. A size value that is not a solid run of ones starting at bit 0 is still applied as a raw mask, and a per-window status bit flags it.

Destination codes are stored as opaque 4-bit values. The intended use is: 0 main memory, 1 on-chip registers, 2 PCIe, 3 PCIe through the chip-to-chip link, 4 boot ROM, 5 external chip-to-chip space, 7 secure-processor RAM, 8 coherent-interconnect registers. Code 6 is unused.

Top module: `addr_win_decode`

## Requirements
- R1: After reset every window is disabled and every register field reads 0. Every lookup then returns `res_hit`=0 and `res_miss`=1.
- R2: `reg_waddr`[4:2] selects window 0 to 4 and `reg_waddr`[1:0] selects the register inside it. The byte offset is `reg_waddr`×4, so the window stride is 0x10. The four registers are: 0 control (bit 0 enable, bits [7:4] destination code), 1 base (bits [23:0] = address bits [39:16]), 2 size (bits [15:0]), and 3 remap (bits [23:0]). A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` shows the addressed register combinationally, with unused bits reading 0.
- R3: Writes to window numbers 5 to 7 change no state, and reads from them return 0.
- R4: Window w hits when it is enabled and (A & ~M) == (base & ~M). Here A = `lk_addr`[39:16] and M = the size field zero-extended to 24 bits. The window then spans (M+1)×64 KB.
- R5: On a hit, `res_addr` = {(remap & ~M) | (A & M), `lk_addr`[15:0]}, and `res_tgt` is the winning window's destination code.
- R6: When several windows hit, the one with the lowest number decides `res_tgt` and `res_addr`.
- R7: A disabled window never hits, and it keeps its base, size, remap and destination values, which read back unchanged.
- R8: When no window hits, `res_miss`=1, `res_hit`=0, `res_tgt`=0 and `res_addr`=0.
- R9: `size_bad`[w] is 1 exactly when window w's size field is not of the form 2^k−1. Such a field is still used as a raw mask.
- R10: `res_valid` equals `lk_valid` and `lk_ready` equals `res_ready` combinationally, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all windows |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Word address {window, register} |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for `reg_waddr` |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup accepted (follows res_ready) |
| lk_addr | input | 40 | Transaction address |
| res_valid | output | 1 | Result valid (follows lk_valid) |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | Some enabled window matched |
| res_miss | output | 1 | No window matched |
| res_tgt | output | 4 | Destination code of winning window |
| res_addr | output | 40 | Translated address |
| size_bad | output | 5 | Per-window malformed-size flags |

## Verification
The assertions assume that `reg_wr`, `reg_waddr` and `reg_wdata` are driven cleanly around the clock edge, and that `lk_addr` is settled whenever outputs are sampled, since the decode path has no register. The stimulus changes inputs only on the falling edge and samples outputs one nanosecond later. Random configurations mostly use well-formed sizes and bases aligned to them, plus a few directed malformed masks and overlapping windows. Addresses are aimed inside a chosen window three times in four so that hits, overlaps and misses all occur often.

// File: rtl/adw_pkg.sv
package adw_pkg;
  localparam int ADDR_W  = 40;
  localparam int GRAN_W  = 16;
  localparam int HI_W    = ADDR_W - GRAN_W;
  localparam int SIZE_W  = 16;
  localparam int TGT_W   = 4;
  localparam int NUM_WIN = 5;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [HI_W-1:0]   base;
    logic [SIZE_W-1:0] size;
    logic [HI_W-1:0]   remap;
  } win_cfg_t;
endpackage

// File: rtl/adw_regs.sv
module adw_regs
  import adw_pkg::*;
#(
  parameter int NWIN  = NUM_WIN,
  parameter int WA_W  = 5,
  localparam int IDX_W = WA_W - 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [WA_W-1:0]           waddr,
  input  logic [HI_W-1:0]           wdata,
  output logic [HI_W-1:0]           rdata,
  output win_cfg_t [NWIN-1:0]       cfg
);
  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  assign idx = waddr[WA_W-1:2];
  assign sel = waddr[1:0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    win_cfg_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (wr && idx == IDX_W'(w)) begin
        unique case (sel)
          2'd0: begin
            r.en  <= wdata[0];
            r.tgt <= wdata[7:4];
          end
          2'd1: r.base  <= wdata;
          2'd2: r.size  <= wdata[SIZE_W-1:0];
          2'd3: r.remap <= wdata;
        endcase
      end
    end
    assign cfg[w] = r;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (idx == IDX_W'(w)) begin
        unique case (sel)
          2'd0: rdata = HI_W'({cfg[w].tgt, 3'b000, cfg[w].en});
          2'd1: rdata = cfg[w].base;
          2'd2: rdata = HI_W'(cfg[w].size);
          2'd3: rdata = cfg[w].remap;
        endcase
      end
    end
  end
endmodule

// File: rtl/adw_match.sv
module adw_match
  import adw_pkg::*;
(
  input  logic              en,
  input  logic [HI_W-1:0]   base,
  input  logic [SIZE_W-1:0] size,
  input  logic [HI_W-1:0]   remap,
  input  logic [HI_W-1:0]   a_hi,
  output logic              hit,
  output logic [HI_W-1:0]   xlat,
  output logic              bad
);
  logic [HI_W-1:0] mask;
  assign mask = HI_W'(size);
  assign hit  = en && ((a_hi & ~mask) == (base & ~mask));
  assign xlat = (remap & ~mask) | (a_hi & mask);
  assign bad  = (size & (size + SIZE_W'(1))) != '0;
endmodule

// File: rtl/adw_prio.sv
module adw_prio
  import adw_pkg::*;
#(
  parameter int NWIN = NUM_WIN
) (
  input  logic [NWIN-1:0]             hit,
  input  logic [NWIN-1:0][TGT_W-1:0]  tgt,
  input  logic [NWIN-1:0][HI_W-1:0]   xlat,
  output logic                        any,
  output logic [TGT_W-1:0]            sel_tgt,
  output logic [HI_W-1:0]             sel_xlat
);
  always_comb begin
    any      = 1'b0;
    sel_tgt  = '0;
    sel_xlat = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        any      = 1'b1;
        sel_tgt  = tgt[w];
        sel_xlat = xlat[w];
      end
    end
  end
endmodule

// File: rtl/addr_win_decode.sv
module addr_win_decode
  import adw_pkg::*;
#(
  parameter int NWIN = NUM_WIN,
  parameter int WA_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [WA_W-1:0]    reg_waddr,
  input  logic [HI_W-1:0]    reg_wdata,
  output logic [HI_W-1:0]    reg_rdata,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic               res_miss,
  output logic [TGT_W-1:0]   res_tgt,
  output logic [ADDR_W-1:0]  res_addr,
  output logic [NWIN-1:0]    size_bad
);
  win_cfg_t [NWIN-1:0]            cfg;
  logic [NWIN-1:0]                w_hit;
  logic [NWIN-1:0][HI_W-1:0]      w_xlat;
  logic [NWIN-1:0][TGT_W-1:0]     w_tgt;
  logic [NWIN-1:0]                en_vec;
  logic                           any;
  logic [TGT_W-1:0]               sel_tgt;
  logic [HI_W-1:0]                sel_xlat;

  adw_regs #(.NWIN(NWIN), .WA_W(WA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_m
    adw_match match_i (
      .en(cfg[w].en), .base(cfg[w].base), .size(cfg[w].size),
      .remap(cfg[w].remap), .a_hi(lk_addr[ADDR_W-1:GRAN_W]),
      .hit(w_hit[w]), .xlat(w_xlat[w]), .bad(size_bad[w])
    );
    assign w_tgt[w]  = cfg[w].tgt;
    assign en_vec[w] = cfg[w].en;
  end

  adw_prio #(.NWIN(NWIN)) prio_i (
    .hit(w_hit), .tgt(w_tgt), .xlat(w_xlat),
    .any(any), .sel_tgt(sel_tgt), .sel_xlat(sel_xlat)
  );

  assign res_hit   = any;
  assign res_miss  = !any;
  assign res_tgt   = sel_tgt;
  assign res_addr  = any ? {sel_xlat, lk_addr[GRAN_W-1:0]} : '0;
  assign res_valid = lk_valid;
  assign lk_ready  = res_ready;
endmodule

// File: rtl/addr_win_decode_chk.sv
module addr_win_decode_chk
  import adw_pkg::*;
#(
  parameter int NWIN = NUM_WIN,
  parameter int WA_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [WA_W-1:0]   reg_waddr,
  input logic [HI_W-1:0]   reg_wdata,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              res_hit,
  input logic              res_miss,
  input logic [TGT_W-1:0]  res_tgt,
  input logic [ADDR_W-1:0] res_addr,
  input logic [NWIN-1:0]   en_vec
);
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_tgt == '0 && res_addr == '0)); // R8
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_addr[GRAN_W-1:0] == lk_addr[GRAN_W-1:0])); // R5
  AST_NO_EN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !res_hit); // R7
  AST_CTRL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_waddr == '0) |=> (en_vec[0] == $past(reg_wdata[0]))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_vec)); // R2
endmodule

bind addr_win_decode addr_win_decode_chk #(.NWIN(NWIN), .WA_W(WA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .lk_addr(lk_addr), .res_hit(res_hit),
  .res_miss(res_miss), .res_tgt(res_tgt), .res_addr(res_addr),
  .en_vec(en_vec)
);

// File: tb/addr_win_decode_tb_top.sv
`timescale 1ns/1ps
module addr_win_decode_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_waddr = 0;
  logic [23:0] reg_wdata = 0;
  logic [23:0] reg_rdata;
  logic        lk_valid = 0, lk_ready, res_valid, res_ready = 1;
  logic [39:0] lk_addr = 0;
  logic        res_hit, res_miss;
  logic [3:0]  res_tgt;
  logic [39:0] res_addr;
  logic [4:0]  size_bad;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit          m_en[5];
  logic [3:0]  m_tgt[5];
  logic [23:0] m_base[5];
  logic [15:0] m_size[5];
  logic [23:0] m_remap[5];

  always #2.5 clk = ~clk;

  addr_win_decode dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_miss(res_miss),
    .res_tgt(res_tgt), .res_addr(res_addr), .size_bad(size_bad)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int w, input int s, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1; reg_waddr = 5'(w * 4 + s); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (w < 5) begin
      case (s)
        0: begin m_en[w] = d[0]; m_tgt[w] = d[7:4]; end
        1: m_base[w] = d;
        2: m_size[w] = d[15:0];
        default: m_remap[w] = d;
      endcase
    end
  endtask

  function automatic logic [23:0] exp_rd(input int w, input int s);
    if (w >= 5) return '0;
    case (s)
      0: return {16'h0, m_tgt[w], 3'b000, m_en[w]};
      1: return m_base[w];
      2: return {8'h0, m_size[w]};
      default: return m_remap[w];
    endcase
  endfunction

  task automatic rd_chk(input int w, input int s, input string req);
    reg_waddr = 5'(w * 4 + s);
    #1;
    check(reg_rdata == exp_rd(w, s), req, 64'(reg_rdata), 64'(exp_rd(w, s)));
  endtask

  function automatic void exp_dec(input logic [39:0] a, output bit h,
                                  output logic [3:0] t, output logic [39:0] o);
    h = 0; t = 0; o = 0;
    for (int w = 0; w < 5; w++) begin
      logic [23:0] msk;
      msk = {8'h0, m_size[w]};
      if (!h && m_en[w] && ((a[39:16] & ~msk) == (m_base[w] & ~msk))) begin
        h = 1; t = m_tgt[w];
        o = {(m_remap[w] & ~msk) | (a[39:16] & msk), a[15:0]};
      end
    end
  endfunction

  function automatic logic [4:0] exp_bad();
    logic [4:0] b;
    for (int w = 0; w < 5; w++) b[w] = (m_size[w] & (m_size[w] + 16'd1)) != 0;
    return b;
  endfunction

  task automatic look(input logic [39:0] a, input string req);
    bit h; logic [3:0] t; logic [39:0] o;
    lk_addr = a;
    #1;
    exp_dec(a, h, t, o);
    check(res_hit == h && res_miss == !h, req, 64'({res_hit, res_miss}), 64'({h, !h}));
    check(res_tgt == t, req, 64'(res_tgt), 64'(t));
    check(res_addr == o, req, 64'(res_addr), 64'(o));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int w = 0; w < 5; w++) begin
      m_en[w] = 0; m_tgt[w] = 0; m_base[w] = 0; m_size[w] = 0; m_remap[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int w = 0; w < 5; w++)
      for (int s = 0; s < 4; s++) rd_chk(w, s, "R1 reset readback");
    look(40'h12_3456_789a, "R1 reset miss");
    look(40'h00_0000_0000, "R1 reset miss zero");
    check(size_bad == 0, "R1 size_bad", 64'(size_bad), 0);

    // R10: pass-through handshake
    lk_valid = 1; res_ready = 0; #1;
    check(res_valid == 1 && lk_ready == 0, "R10 backpressure", 64'({res_valid, lk_ready}), 64'b10);
    lk_valid = 0; res_ready = 1; #1;
    check(res_valid == 0 && lk_ready == 1, "R10 pass", 64'({res_valid, lk_ready}), 64'b01);
    lk_valid = 1;

    // R2 R4 R5: window 1 16 MB at 0x1_0000_0000 remapped to 0x20_0000_0000
    wr_reg(1, 1, 24'h01_0000);
    wr_reg(1, 2, 24'h00_00ff);
    wr_reg(1, 3, 24'h20_0000);
    wr_reg(1, 0, 24'h0000_51);
    for (int s = 0; s < 4; s++) rd_chk(1, s, "R2 readback");
    look(40'h01_00ab_cdef, "R4 R5 inside");
    look(40'h01_00ff_ffff, "R4 top edge");
    look(40'h01_0100_0000, "R8 just past");
    look(40'h00_ffff_ffff, "R8 just below");

    // R6: overlap, window 0 covers a 64 KB piece of window 1
    wr_reg(0, 1, 24'h01_0040);
    wr_reg(0, 2, 24'h00_0000);
    wr_reg(0, 3, 24'h03_0000);
    wr_reg(0, 0, 24'h0000_21);
    look(40'h01_0040_1234, "R6 low index wins");
    look(40'h01_0041_1234, "R6 other window");

    // R7: disable window 1, values kept
    wr_reg(1, 0, 24'h0000_50);
    for (int s = 0; s < 4; s++) rd_chk(1, s, "R7 kept");
    look(40'h01_0022_0000, "R7 disabled miss");

    // R3: writes above window 4 ignored
    wr_reg(5, 0, 24'hffffff);
    wr_reg(7, 1, 24'hffffff);
    rd_chk(5, 0, "R3 read zero");
    rd_chk(7, 1, "R3 read zero");
    for (int w = 0; w < 5; w++) rd_chk(w, 0, "R3 no side effect");
    look(40'hff_ffff_0000, "R3 no new window");

    // R9: malformed mask 0x00F0 on window 2
    wr_reg(0, 0, 24'h0);
    wr_reg(2, 1, 24'h00_0100);
    wr_reg(2, 2, 24'h00_00f0);
    wr_reg(2, 3, 24'h00_0900);
    wr_reg(2, 0, 24'h0000_81);
    #1;
    check(size_bad == 5'b00100, "R9 flag", 64'(size_bad), 64'(5'b00100));
    look(40'h00_01a0_0000, "R9 raw mask hit");
    look(40'h00_01a1_0000, "R9 raw mask miss");

    // Random rounds
    for (int rnd = 0; rnd < 30; rnd++) begin
      for (int w = 0; w < 5; w++) begin
        logic [15:0] sz;
        int k;
        k = $urandom_range(16, 0);
        sz = 16'((32'h1 << k) - 1);
        if ($urandom_range(7, 0) == 0) sz = 16'($urandom);
        wr_reg(w, 0, 24'h0);
        wr_reg(w, 2, {8'h0, sz});
        wr_reg(w, 1, 24'($urandom) & ~{8'h0, sz});
        wr_reg(w, 3, 24'($urandom));
        wr_reg(w, 0, {16'h0, 4'($urandom_range(8, 0)), 3'b000, 1'($urandom_range(3, 0) != 0)});
      end
      #1;
      check(size_bad == exp_bad(), "R9 random flags", 64'(size_bad), 64'(exp_bad()));
      for (int i = 0; i < 20; i++) begin
        logic [39:0] a;
        int w;
        a = {8'($urandom), 32'($urandom)};
        if ($urandom_range(3, 0) != 0) begin
          w = $urandom_range(4, 0);
          a[39:16] = (m_base[w] & ~{8'h0, m_size[w]}) | (a[39:16] & {8'h0, m_size[w]});
        end
        @(negedge clk);
        look(a, "R4 R5 R6 R7 R8 random");
      end
      rd_chk($urandom_range(4, 0), $urandom_range(3, 0), "R2 random readback");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule